// File: doc/BRIEF.md
# Sequential Remainder-by-Ten Unit

This block reduces a 16-bit unsigned operand to its remainder modulo ten and returns it as a 4-bit result. It does not use a general divider. The divisor ten is stored in a second register as a pre-shifted negative value: minus ten shifted left by twelve places, in two's complement. On each step one adder sums the working remainder with this negative divisor. The sum replaces the working remainder only when the adder produces a carry out, because a carry out means the subtraction did not go below zero. After each step the divisor register shifts right by one place and a one is shifted into its top bit. After a fixed thirteen steps the low four bits of the working remainder are the answer.

To start an operation, a caller raises a one-cycle start pulse together with the operand while the unit is idle. Exactly fourteen cycles later the result appears with a one-cycle valid pulse. The result stays on its output until the next operation completes. The controller has three states: idle, run (13 steps counted by a step counter) and done.

Top module: `rem10_unit`

## Requirements
- R1: While the synchronous active-high reset is asserted, rem_valid is 0 and rem_value is 0. A reset during an operation abandons it, and that operation produces no rem_valid pulse.
- R2: For every operand, including 0, 9, 10 and 65535, the reported rem_value equals op_value mod 10 and is below 10.
- R3: Each accepted operation produces exactly one rem_valid pulse, and that pulse is one cycle long.
- R4: If op_valid is sampled high in cycle c, rem_valid is high in cycle c+14, for every operand.
- R5: rem_value changes only in a cycle where rem_valid is high or reset is asserted. It keeps its last result while a later operation runs and while the unit is idle.
- R6: An op_valid pulse in any cycle from the accepting cycle up to and including the rem_valid cycle is ignored. It produces no extra rem_valid pulse, and it does not change the result of the operation in progress.
- R7: An op_valid pulse in the cycle right after rem_valid is accepted, so operations can run back to back with no idle gap.
- R8: Operand 56789 yields 9, operand 8192 yields 2 and operand 310 yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle start pulse; accepted only when the unit is idle |
| op_value | input | 16 | Unsigned operand, sampled with op_valid |
| rem_valid | output | 1 | One-cycle pulse marking a new result |
| rem_value | output | 4 | Remainder modulo ten; holds until the next result |

## Verification
The hardest case to reach from the ports is a start pulse that arrives while the unit is busy, and in particular one that lands in the done cycle itself. Done is the last cycle before the unit returns to idle. The stimulus places a second pulse a few steps into a run and a third pulse exactly in the result cycle. The scoreboard holds no entry for either pulse, so any extra result or any corrupted result is reported. Back-to-back operations with no idle cycle between them are the normal traffic pattern here, so the cycle where done returns to idle is always exercised against a waiting start. A reset in the middle of a run checks that the abandoned operation produces no result.

// File: rtl/rem10_pkg.sv
package rem10_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } rem10_state_t;

  localparam int unsigned DIVISOR = 10;
endpackage

// File: rtl/rem10_dp.sv
module rem10_dp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] operand,
  output logic         carry,
  output logic [W-1:0] r_cur,
  output logic [W-1:0] r_next
);
  import rem10_pkg::*;

  localparam int STEPS = W - 3;

  // negative divisor, aligned so that the first trial subtracts DIVISOR << (STEPS-1)
  function automatic logic [W-1:0] seed_value();
    logic [W-1:0] neg;
    neg = ~W'(DIVISOR) + W'(1);
    return neg << (STEPS - 1);
  endfunction

  // trial sum with carry kept in the top bit
  function automatic logic [W:0] trial_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  localparam logic [W-1:0] SEED = seed_value();

  logic [W-1:0] r_q;
  logic [W-1:0] s_q;
  logic [W:0]   sum_w;

  assign sum_w  = trial_sum(r_q, s_q);
  assign carry  = sum_w[W];
  assign r_cur  = r_q;
  assign r_next = carry ? sum_w[W-1:0] : r_q;

  always_ff @(posedge clk) begin
    if (load) begin
      r_q <= operand;
      s_q <= SEED;
    end else if (step) begin
      r_q <= r_next;
      s_q <= {1'b1, s_q[W-1:1]};
    end
  end
endmodule

// File: rtl/rem10_ctrl.sv
module rem10_ctrl #(
  parameter int STEPS = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic capture,
  output logic done,
  output logic busy
);
  import rem10_pkg::*;

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  rem10_state_t state_q;
  logic [CW-1:0] cnt_q;
  logic          last_w;

  assign last_w  = (state_q == ST_RUN) && (cnt_q == CW'(STEPS - 1));
  assign load    = (state_q == ST_IDLE) && start;
  assign step    = (state_q == ST_RUN);
  assign capture = last_w;
  assign done    = (state_q == ST_DONE);
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start) state_q <= ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CW'(1);
          if (last_w) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rem10_out.sv
module rem10_out #(
  parameter int W  = 16,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [W-1:0]  r_final,
  output logic [OW-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else if (capture) value <= r_final[OW-1:0];
  end
endmodule

// File: rtl/rem10_unit.sv
module rem10_unit #(
  parameter int W  = 16,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [W-1:0]  op_value,
  output logic          rem_valid,
  output logic [OW-1:0] rem_value
);
  localparam int STEPS = W - 3;

  // named internal events, observed by the bound checker
  logic         load_w;
  logic         step_w;
  logic         capture_w;
  logic         busy_w;
  logic         carry_w;
  logic [W-1:0] r_w;
  logic [W-1:0] r_next_w;

  rem10_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst(rst), .start(op_valid),
    .load(load_w), .step(step_w), .capture(capture_w),
    .done(rem_valid), .busy(busy_w)
  );

  rem10_dp #(.W(W)) u_dp (
    .clk(clk), .load(load_w), .step(step_w), .operand(op_value),
    .carry(carry_w), .r_cur(r_w), .r_next(r_next_w)
  );

  rem10_out #(.W(W), .OW(OW)) u_out (
    .clk(clk), .rst(rst), .capture(capture_w),
    .r_final(r_next_w), .value(rem_value)
  );
endmodule

// File: rtl/rem10_unit_chk.sv
module rem10_unit_chk #(
  parameter int W  = 16,
  parameter int OW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          accept,
  input logic          run,
  input logic          rem_valid,
  input logic [OW-1:0] rem_value,
  input logic [W-1:0]  r_val
);
  localparam int STEPS = W - 3;
  localparam int LW    = $clog2(STEPS + 2) + 1;

  logic [LW-1:0] lat_q;
  logic          pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q     <= '0;
      pending_q <= 1'b0;
    end else begin
      if (accept) begin
        lat_q     <= LW'(1);
        pending_q <= 1'b1;
      end else if (pending_q && lat_q != '1) begin
        lat_q <= lat_q + LW'(1);
      end
      if (rem_valid) pending_q <= 1'b0;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!rem_valid && rem_value == '0));

  assert_result_range_R2: assert property (@(posedge clk) disable iff (rst)
    rem_valid |-> (rem_value < OW'(10)));

  assert_no_growth_R2: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> (r_val <= $past(r_val)));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rem_valid |=> !rem_valid);

  assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (rst)
    rem_valid |-> (pending_q && lat_q == LW'(STEPS + 1)));

  assert_hold_result_R5: assert property (@(posedge clk) disable iff (rst)
    !rem_valid |=> (rem_valid || $stable(rem_value)));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    accept |-> !pending_q);
endmodule

bind rem10_unit rem10_unit_chk #(.W(W), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .accept(load_w), .run(step_w),
  .rem_valid(rem_valid), .rem_value(rem_value), .r_val(r_w)
);

// File: tb/sim_rem10_unit.sv
module sim_rem10_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [15:0] op_value = '0;
  logic        rem_valid;
  logic [3:0]  rem_value;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int exp_y[$];
  int exp_t[$];
  int last_y = 0;
  bit prev_v = 1'b0;
  bit finished = 1'b0;

  rem10_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_value(op_value),
    .rem_valid(rem_valid), .rem_value(rem_value)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: scoreboard pop/compare, pulse shape, hold and reset behaviour
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        check(!rem_valid && rem_value == 4'd0, "R1 reset state", int'(rem_value), 0);
        last_y = 0;
        prev_v = 1'b0;
      end else begin
        if (rem_valid) begin
          check(!prev_v, "R3 pulse longer than one cycle", 1, 0);
          if (exp_y.size() == 0) begin
            check(1'b0, "R6 unexpected rem_valid", int'(rem_value), -1);
          end else begin
            int ey, et;
            ey = exp_y.pop_front();
            et = exp_t.pop_front();
            check(int'(rem_value) == ey, "R2 remainder", int'(rem_value), ey);
            check(cyc - et == 14, "R4 latency", cyc - et, 14);
          end
          last_y = int'(rem_value);
        end else begin
          check(int'(rem_value) == last_y, "R5 result held", int'(rem_value), last_y);
        end
        prev_v = rem_valid;
      end
    end
  end

  // driver: called at a negedge, returns one negedge later
  task automatic send(input int x, input bit push);
    op_value = 16'(x);
    op_valid = 1'b1;
    if (push) begin
      exp_y.push_back(x % 10);
      exp_t.push_back(cyc);
    end
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // full operation; leaves the bench in the cycle right after rem_valid (R7)
  task automatic op(input int x);
    send(x, 1'b1);
    repeat (14) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // boundary operands, back to back (R2, R7)
    op(0); op(9); op(10); op(65535); op(40960); op(40959); op(19);
    // R8 worked examples
    op(56789); check(last_y == 9, "R8 56789", last_y, 9);
    op(8192);  check(last_y == 2, "R8 8192", last_y, 2);
    op(310);   check(last_y == 0, "R8 310", last_y, 0);
    // random operands with occasional idle gaps (R2, R4, R5)
    for (int i = 0; i < 1000; i++) begin
      op(int'($urandom_range(0, 65535)));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 5)) @(negedge clk);
    end
    // R6: pulses while running and in the result cycle are ignored
    send(12345, 1'b1);
    repeat (3) @(negedge clk);
    send(777, 1'b0);
    repeat (9) @(negedge clk);
    send(4, 1'b0);
    repeat (20) @(negedge clk);
    check(int'(rem_value) == 5, "R6 busy pulse ignored", int'(rem_value), 5);
    check(exp_y.size() == 0, "R6 no pending result", exp_y.size(), 0);
    // R1: reset in the middle of a run abandons it
    send(1234, 1'b0);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check(int'(rem_value) == 0, "R1 aborted op gives no result", int'(rem_value), 0);
    op(77);
    check(last_y == 7, "R7 accept after reset", last_y, 7);
    repeat (3) @(negedge clk);
    check(exp_y.size() == 0, "R3 every op produced a result", exp_y.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule